// File: doc/BRIEF.md
# Processor Interrupt Pin Controller

This block stands between a processor core and the interrupt and control pins that come from outside it. All seven pins first pass through a synchronizer. The block then compares each synchronized pin with the level it last recorded for that pin. When the two differ, the block handles the change according to that pin's own rule. A pin can follow its level into a pending bit, latch a falling edge, set a sticky halt, fire a one-cycle reset request, or gate the time base.

The core sees two things. One is a four-bit pending vector. The other is a single interrupt request that is the OR of that vector. The machine-check cause is latched and stays set, so the core acknowledges it with a per-bit clear pulse. The other pending causes follow their pins and ignore the clear. Halt, hard-reset pulse and time-base enable are separate outputs.

Top module: `irq_pin_ctrl`

## Requirements
- R1: A pin whose synchronized level equals its recorded level causes no event. A pin held low from reset never sets machine check. A machine check that has been cleared is not set again while the pin stays low.
- R2: The external-interrupt pin sets pending bit 0 when it rises and clears it when it falls. The system-management pin does the same for pending bit 1.
- R3: A high-to-low change on the machine-check pin sets pending bit 2. A low-to-high change leaves bit 2 as it was.
- R4: A rising checkstop pin sets `halt_o`. Only the synchronous reset clears it. A falling checkstop pin leaves it set.
- R5: A rising hard-reset pin makes `hreset_req_o` high for exactly one cycle. A falling hard-reset pin makes no pulse.
- R6: The soft-reset pin sets pending bit 3 on a rising level and clears it on a falling level.
- R7: `tb_en_o` goes high when the time-base pin rises and low when it falls.
- R8: `irq_o` is high while any pending bit is set. It goes low only once all four bits are clear.
- R9: `pend_clr_i[2]` clears pending bit 2 on the next edge. Clear bits 0, 1 and 3 have no effect, because those causes follow their pins.
- R10: When a machine-check falling edge and the clear arrive in the same cycle, the set wins.
- R11: A pin change reaches the outputs on the third rising clock edge after it. With the default of two synchronizer stages, two stages come first and the state register comes third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_irq_i | input | 1 | External interrupt pin, active high |
| smi_i | input | 1 | System-management interrupt pin, active high |
| mchk_i | input | 1 | Machine-check pin, falling edge latched |
| chkstop_i | input | 1 | Checkstop pin, asserted high |
| hreset_i | input | 1 | Hard-reset pin, asserted high |
| sreset_i | input | 1 | Soft-reset pin, level |
| tben_i | input | 1 | Time-base enable pin, level |
| pend_clr_i | input | 4 | Per-bit acknowledge pulse for pending bits |
| pend_o | output | 4 | Pending vector: 0 external, 1 system-management, 2 machine check, 3 soft reset |
| irq_o | output | 1 | OR of the pending vector |
| halt_o | output | 1 | Sticky halt request |
| hreset_req_o | output | 1 | One-cycle hard-reset request |
| tb_en_o | output | 1 | Time-base run enable |

## Verification
The hardest case to reach is a machine-check falling edge that lands in the same cycle as its clear. The edge is only seen three clocks after the pin moves, so the clear has to be placed against that delay. The bench drops the pin on a falling clock edge and counts two rising edges. It then raises the clear just before the third edge, so that the set and the clear meet in one cycle. A second hard case is a machine-check pin that stays low after an acknowledge. The bench watches it for many cycles to show that no new event is made.

// File: rtl/irqpin_pkg.sv
package irqpin_pkg;

    // Pin lane numbering inside the synchronized vector
    localparam int NUM_PINS  = 7;
    localparam int PIN_EXT   = 0;
    localparam int PIN_SMI   = 1;
    localparam int PIN_MCHK  = 2;
    localparam int PIN_CSTOP = 3;
    localparam int PIN_HRST  = 4;
    localparam int PIN_SRST  = 5;
    localparam int PIN_TBEN  = 6;

    // Pending vector layout seen by the core
    localparam int PEND_W   = 4;
    localparam int PND_EXT  = 0;
    localparam int PND_SMI  = 1;
    localparam int PND_MCHK = 2;
    localparam int PND_SRST = 3;

    typedef logic [NUM_PINS-1:0] pin_vec_t;
    typedef logic [PEND_W-1:0]   pend_vec_t;

    // Change events derived from the last-level comparison
    typedef struct packed {
        pin_vec_t rise;
        pin_vec_t fall;
    } pin_evt_t;

    typedef enum logic [1:0] {
        SEM_FOLLOW,
        SEM_FALL_LATCH
    } pend_sem_e;

    // How each pending bit reacts to its source pin
    function automatic pend_sem_e pend_sem(input int idx);
        return (idx == PND_MCHK) ? SEM_FALL_LATCH : SEM_FOLLOW;
    endfunction

    // Source pin lane for each pending bit
    function automatic int pend_src(input int idx);
        case (idx)
            PND_EXT:  return PIN_EXT;
            PND_SMI:  return PIN_SMI;
            PND_MCHK: return PIN_MCHK;
            default:  return PIN_SRST;
        endcase
    endfunction

endpackage

// File: rtl/irqpin_sync.sv
module irqpin_sync #(
    parameter int STAGES = 2,
    parameter int W      = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg_q[0] <= '0;
                    else     stg_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg_q[s] <= '0;
                    else     stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/irqpin_edge.sv
module irqpin_edge
    import irqpin_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t lvl_i,
    output pin_evt_t evt_o
);
    pin_vec_t last_q;
    pin_vec_t diff;

    // Only a difference from the recorded level counts as an event
    assign diff       = lvl_i ^ last_q;
    assign evt_o.rise = diff & lvl_i;
    assign evt_o.fall = diff & ~lvl_i;

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= lvl_i;
    end
endmodule

// File: rtl/irqpin_pend.sv
module irqpin_pend
    import irqpin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_evt_t  evt_i,
    input  pend_vec_t clr_i,
    output pend_vec_t pend_o
);
    pend_vec_t pend_q;

    generate
        for (genvar i = 0; i < PEND_W; i++) begin : g_bit
            localparam int SRC = pend_src(i);
            if (pend_sem(i) == SEM_FALL_LATCH) begin : g_latch
                // Falling edge sets; acknowledge clears; set wins
                always_ff @(posedge clk) begin
                    if (rst)                   pend_q[i] <= 1'b0;
                    else if (evt_i.fall[SRC])  pend_q[i] <= 1'b1;
                    else if (clr_i[i])         pend_q[i] <= 1'b0;
                end
            end else begin : g_follow
                // Bit tracks pin level; acknowledge is ignored
                always_ff @(posedge clk) begin
                    if (rst)                   pend_q[i] <= 1'b0;
                    else if (evt_i.rise[SRC])  pend_q[i] <= 1'b1;
                    else if (evt_i.fall[SRC])  pend_q[i] <= 1'b0;
                end
            end
        end
    endgenerate

    assign pend_o = pend_q;

    logic unused_evt;
    assign unused_evt = ^{evt_i.rise[PIN_CSTOP], evt_i.rise[PIN_HRST], evt_i.rise[PIN_TBEN],
                          evt_i.fall[PIN_CSTOP], evt_i.fall[PIN_HRST], evt_i.fall[PIN_TBEN],
                          evt_i.rise[PIN_MCHK]};

    // R1: quiet pins and no acknowledge leave the vector untouched
    assert_quiet_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (evt_i.rise == '0 && evt_i.fall == '0 && clr_i == '0) |=> $stable(pend_q));

    // R3: a rising machine-check pin does not alter the latched bit
    assert_mchk_rise_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (evt_i.rise[PIN_MCHK] && !clr_i[PND_MCHK]) |=> $stable(pend_q[PND_MCHK]));

    // R9: acknowledge on a following bit has no effect
    assert_follow_no_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_i[PND_EXT] && !evt_i.rise[PIN_EXT] && !evt_i.fall[PIN_EXT])
        |=> $stable(pend_q[PND_EXT]));

    // R10: falling edge beats a simultaneous acknowledge
    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
        evt_i.fall[PIN_MCHK] |=> pend_q[PND_MCHK]);
endmodule

// File: rtl/irqpin_ctl.sv
module irqpin_ctl
    import irqpin_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_evt_t evt_i,
    output logic     halt_o,
    output logic     hreset_req_o,
    output logic     tb_en_o
);
    logic halt_q;
    logic hrst_q;
    logic tben_q;

    // Checkstop: sticky until reset
    always_ff @(posedge clk) begin
        if (rst)                      halt_q <= 1'b0;
        else if (evt_i.rise[PIN_CSTOP]) halt_q <= 1'b1;
    end

    // Hard reset: one-cycle request on assertion only
    always_ff @(posedge clk) begin
        if (rst) hrst_q <= 1'b0;
        else     hrst_q <= evt_i.rise[PIN_HRST];
    end

    // Time base enable follows its pin
    always_ff @(posedge clk) begin
        if (rst)                        tben_q <= 1'b0;
        else if (evt_i.rise[PIN_TBEN])  tben_q <= 1'b1;
        else if (evt_i.fall[PIN_TBEN])  tben_q <= 1'b0;
    end

    assign halt_o       = halt_q;
    assign hreset_req_o = hrst_q;
    assign tb_en_o      = tben_q;

    logic unused_evt;
    assign unused_evt = ^{evt_i.rise[PIN_EXT], evt_i.rise[PIN_SMI], evt_i.rise[PIN_MCHK],
                          evt_i.rise[PIN_SRST], evt_i.fall[PIN_EXT], evt_i.fall[PIN_SMI],
                          evt_i.fall[PIN_MCHK], evt_i.fall[PIN_SRST], evt_i.fall[PIN_CSTOP],
                          evt_i.fall[PIN_HRST]};

    // R4: halt holds until reset
    assert_halt_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        halt_q |=> halt_q);

    // R5: reset request never lasts two cycles
    assert_hreset_single_R5: assert property (@(posedge clk) disable iff (rst)
        hrst_q |=> !hrst_q);

    // R7: falling time-base pin stops the time base
    assert_tben_fall_R7: assert property (@(posedge clk) disable iff (rst)
        evt_i.fall[PIN_TBEN] |=> !tben_q);
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irqpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_irq_i,
    input  logic              smi_i,
    input  logic              mchk_i,
    input  logic              chkstop_i,
    input  logic              hreset_i,
    input  logic              sreset_i,
    input  logic              tben_i,
    input  logic [PEND_W-1:0] pend_clr_i,
    output logic [PEND_W-1:0] pend_o,
    output logic              irq_o,
    output logic              halt_o,
    output logic              hreset_req_o,
    output logic              tb_en_o
);
    pin_vec_t  pins_raw;
    pin_vec_t  pins_sync;
    pin_evt_t  evt;
    pend_vec_t pend;

    always_comb begin
        pins_raw            = '0;
        pins_raw[PIN_EXT]   = ext_irq_i;
        pins_raw[PIN_SMI]   = smi_i;
        pins_raw[PIN_MCHK]  = mchk_i;
        pins_raw[PIN_CSTOP] = chkstop_i;
        pins_raw[PIN_HRST]  = hreset_i;
        pins_raw[PIN_SRST]  = sreset_i;
        pins_raw[PIN_TBEN]  = tben_i;
    end

    irqpin_sync #(.STAGES(SYNC_STAGES), .W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pins_raw),
        .sync_o  (pins_sync)
    );

    irqpin_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (pins_sync),
        .evt_o (evt)
    );

    irqpin_pend u_pend (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .clr_i  (pend_clr_i),
        .pend_o (pend)
    );

    irqpin_ctl u_ctl (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt),
        .halt_o       (halt_o),
        .hreset_req_o (hreset_req_o),
        .tb_en_o      (tb_en_o)
    );

    assign pend_o = pend;
    assign irq_o  = |pend;

    // R8: the request can only drop on a cycle where the vector emptied
    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> (pend_o == '0));

    // R2: a rising external pin event shows in bit 0 next cycle
    assert_ext_follow_R2: assert property (@(posedge clk) disable iff (rst)
        evt.rise[PIN_EXT] |=> pend_o[PND_EXT]);
endmodule

// File: tb/irq_pin_ctrl_bench.sv
module irq_pin_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       ext_irq, smi, mchk, cstop, hrst, srst, tben;
    logic [3:0] clr;
    logic [3:0] pend;
    logic       irq, halt, hreq, tben_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pin_ctrl u_irq_pin_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ext_irq_i    (ext_irq),
        .smi_i        (smi),
        .mchk_i       (mchk),
        .chkstop_i    (cstop),
        .hreset_i     (hrst),
        .sreset_i     (srst),
        .tben_i       (tben),
        .pend_clr_i   (clr),
        .pend_o       (pend),
        .irq_o        (irq),
        .halt_o       (halt),
        .hreset_req_o (hreq),
        .tb_en_o      (tben_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Inputs are changed on a falling edge; wait for the three rising edges
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {ext_irq, smi, mchk, cstop, hrst, srst, tben} = '0;
        clr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R8 reset pend", pend, 0);
        chk("R8 reset irq", irq, 0);
        chk("R4 reset halt", halt, 0);
        chk("R5 reset hreq", hreq, 0);
        chk("R7 reset tb_en", tben_o, 0);
    endtask

    task automatic t_latency();
        ext_irq = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 not yet after two edges", pend[0], 0);
        @(posedge clk);
        @(negedge clk);
        chk("R11 visible after third edge", pend[0], 1);
        ext_irq = 1'b0;
        settle();
    endtask

    task automatic t_level_pins();
        ext_irq = 1'b1; settle();
        chk("R2 ext high", pend, 4'b0001);
        chk("R8 irq ext", irq, 1);
        smi = 1'b1; settle();
        chk("R2 smi high", pend, 4'b0011);
        ext_irq = 1'b0; settle();
        chk("R2 ext low", pend, 4'b0010);
        chk("R8 irq held by smi", irq, 1);
        smi = 1'b0; settle();
        chk("R2 smi low", pend, 4'b0000);
        chk("R8 irq drops", irq, 0);
    endtask

    task automatic t_mchk();
        repeat (8) @(negedge clk);
        chk("R1 low from reset no event", pend[2], 0);
        mchk = 1'b1; settle();
        chk("R3 rise no effect", pend[2], 0);
        mchk = 1'b0; settle();
        chk("R3 fall latches", pend[2], 1);
        chk("R8 irq by mchk", irq, 1);
        mchk = 1'b1; settle();
        chk("R3 rise keeps latch", pend[2], 1);
        clr = 4'b0100;
        @(negedge clk);
        clr = 4'b0000;
        chk("R9 clear mchk", pend[2], 0);
        chk("R8 irq after clear", irq, 0);
        mchk = 1'b0; settle();
        clr = 4'b0100;
        @(negedge clk);
        clr = 4'b0000;
        repeat (20) @(negedge clk);
        chk("R1 held low no relatch", pend[2], 0);
    endtask

    task automatic t_clear_ignored();
        ext_irq = 1'b1; srst = 1'b1; settle();
        clr = 4'b1011;
        @(negedge clk);
        clr = 4'b0000;
        @(negedge clk);
        chk("R9 clear ignored on follow bits", pend, 4'b1001);
        ext_irq = 1'b0; srst = 1'b0; settle();
        chk("R6 srst low clears", pend[3], 0);
    endtask

    task automatic t_set_beats_clear();
        mchk = 1'b1; settle();
        mchk = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        clr = 4'b0100;
        @(negedge clk);
        clr = 4'b0000;
        chk("R10 set wins over clear", pend[2], 1);
        clr = 4'b0100;
        @(negedge clk);
        clr = 4'b0000;
        chk("R10 later clear works", pend[2], 0);
    endtask

    task automatic t_srst();
        srst = 1'b1; settle();
        chk("R6 srst high", pend, 4'b1000);
        chk("R8 irq srst", irq, 1);
        srst = 1'b0; settle();
        chk("R6 srst low", pend, 4'b0000);
    endtask

    task automatic t_hreset();
        int seen = 0;
        hrst = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (hreq) seen++;
        end
        chk("R5 one pulse on assert", seen, 1);
        seen = 0;
        hrst = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (hreq) seen++;
        end
        chk("R5 no pulse on deassert", seen, 0);
    endtask

    task automatic t_tben();
        tben = 1'b1; settle();
        chk("R7 tb_en high", tben_o, 1);
        tben = 1'b0; settle();
        chk("R7 tb_en low", tben_o, 0);
    endtask

    task automatic t_checkstop();
        cstop = 1'b1; settle();
        chk("R4 halt on assert", halt, 1);
        cstop = 1'b0; settle();
        chk("R4 halt held after deassert", halt, 1);
        do_reset();
        chk("R4 reset releases halt", halt, 0);
    endtask

    initial begin
        rst = 1'b1;
        {ext_irq, smi, mchk, cstop, hrst, srst, tben} = '0;
        clr = '0;
        do_reset();
        t_reset_state();
        t_latency();
        t_level_pins();
        t_mchk();
        t_clear_ignored();
        t_set_beats_clear();
        t_srst();
        t_hreset();
        t_tben();
        t_checkstop();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule